// File: doc/BRIEF.md
# Triangular Loop-Nest Product Engine

This block steps through a triangular two-level loop nest and builds a result vector B from a square matrix A. Entry B[k] ends up as the product, truncated to the data width, of every A element whose row and column indices add up to k, for k from 0 to a run-time bound n. A sits in a synchronous memory outside the block with a one-cycle read latency; B lives in a second memory outside the block, reached through one port that can read or write.

A one-bit mode input picks the iteration order. In row order the outer index i runs from 0 to n and the inner index j from 0 to n-i. Each element of B is first set to one while i is zero, and every update is a read-modify-write of B. In diagonal order the loop is re-indexed so that the outer index is the sum i+j. Each B element is then built in a local accumulator and stored once. Both orders give the same B. The block counts its own B reads, B writes and A reads for the last run, so the memory traffic of the two orders can be compared.

A start pulse latches the mode and the bound and begins a run. One sequencer executes every statement instance in turn; no two instances overlap. A one-cycle done pulse ends the run.

Top module: `tri_nest_engine`

## Requirements
- R1: After reset, busy and done are 0, no A or B access strobe is active, and all three access counters read 0.
- R2: After a run with bound n, B[k] equals the product, modulo 2^DATA_W, of A[r][k-r] for r = 0..k, for every k in 0..n. B entries above n are not written.
- R3: With mode = 0 (row order), i runs 0..n outermost and j runs 0..n-i innermost. While i = 0, B[j] is written with 1 before its update. Each update reads A[i][j] and B[i+j] and writes back their product. With T = (n+1)(n+2)/2, the counters end at A reads = T, B reads = T and B writes = T+n+1.
- R4: With mode = 1 (diagonal order), for each s in 0..n an accumulator is set to 1 and multiplied by A[s-j][j] for j = 0..s, then written once to B[s]. B is never read. The counters end at A reads = T, B reads = 0 and B writes = n+1.
- R5: For the same A and n, both modes leave identical B contents.
- R6: A read data is used exactly one cycle after the read strobe. Every A read address satisfies row+col <= n. A B read and a B write are never strobed in the same cycle.
- R7: busy is 1 from the cycle after an accepted start until the done cycle. done is high for exactly one cycle, in the cycle directly after the last B write, and the block is idle again afterwards.
- R8: A start pulse while busy is 1 is ignored: the run in progress keeps its mode, bound and results.
- R9: An accepted start clears the three counters. After done they hold their values until the next accepted start.
- R10: For n >= 2, B reads plus B writes in diagonal mode are fewer than in row mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse; accepted only while busy is 0 |
| mode | input | 1 | 0 = row order, 1 = diagonal order; latched at start |
| n_in | input | IDX_W | Loop bound n; latched at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| a_rd_en | output | 1 | A read strobe |
| a_row | output | IDX_W | A row index |
| a_col | output | IDX_W | A column index |
| a_rd_data | input | DATA_W | A read data, valid one cycle after a_rd_en |
| b_rd_en | output | 1 | B read strobe |
| b_wr_en | output | 1 | B write strobe |
| b_addr | output | IDX_W | B address for read or write |
| b_wr_data | output | DATA_W | B write data |
| b_rd_data | input | DATA_W | B read data, valid one cycle after b_rd_en |
| cnt_b_rd | output | CNT_W | B reads in the last run |
| cnt_b_wr | output | CNT_W | B writes in the last run |
| cnt_a_rd | output | CNT_W | A reads in the last run |

## Verification
Both orders are run on the same matrix for bounds 0, 1, 2, 5 and 7. This separates a wrong triangle edge, which shows up in the entries for the largest k, from a wrong one-row case at bound 0. Random matrices catch wrong operand pairing or a wrong latency. A matrix of all ones checks that the initial value is one and that nothing extra is multiplied in. A matrix of twos gives a result that depends only on the number of factors, so it checks the count of factors per diagonal. A matrix of all-ones words checks truncation, since the sign of each result depends on whether the number of factors is odd. A start pulse in the middle of a row-order run, carrying the other mode and a smaller bound, must leave that run's results and counts unchanged.

// File: rtl/tri_nest_pkg.sv
package tri_nest_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_R_INIT,
    ST_R_FETCH,
    ST_R_UPD,
    ST_D_INIT,
    ST_D_FETCH,
    ST_D_MAC,
    ST_D_STORE,
    ST_DONE
  } nest_state_e;

  typedef enum logic [1:0] {
    WS_ONE,
    WS_PROD,
    WS_ACC
  } wsel_e;

  localparam logic MODE_ROW  = 1'b0;
  localparam logic MODE_DIAG = 1'b1;

endpackage

// File: rtl/tri_nest_ctrl.sv
module tri_nest_ctrl
  import tri_nest_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [IDX_W-1:0] n_in,
  output logic             busy,
  output logic             done,
  output logic             a_rd,
  output logic [IDX_W-1:0] a_row,
  output logic [IDX_W-1:0] a_col,
  output logic             b_rd,
  output logic             b_wr,
  output logic [IDX_W-1:0] b_addr,
  output wsel_e            wsel,
  output logic             acc_init,
  output logic             acc_mul
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  nest_state_e      st_q, st_d;
  logic             mode_q, mode_d;
  logic [IDX_W-1:0] nb_q, nb_d;
  logic [IDX_W-1:0] i_q, i_d;
  logic [IDX_W-1:0] j_q, j_d;
  logic             row_last_j;

  assign row_last_j = (j_q == (nb_q - i_q));

  // next-state process
  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    nb_d   = nb_q;
    i_d    = i_q;
    j_d    = j_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          mode_d = mode;
          nb_d   = n_in;
          i_d    = '0;
          j_d    = '0;
          st_d   = (mode == MODE_DIAG) ? ST_D_INIT : ST_R_INIT;
        end
      end
      ST_R_INIT:  st_d = ST_R_FETCH;
      ST_R_FETCH: st_d = ST_R_UPD;
      ST_R_UPD: begin
        if (row_last_j) begin
          if (i_q == nb_q) begin
            st_d = ST_DONE;
          end else begin
            i_d  = i_q + IDX_ONE;
            j_d  = '0;
            st_d = ST_R_FETCH;
          end
        end else begin
          j_d  = j_q + IDX_ONE;
          st_d = (i_q == '0) ? ST_R_INIT : ST_R_FETCH;
        end
      end
      ST_D_INIT: begin
        j_d  = '0;
        st_d = ST_D_FETCH;
      end
      ST_D_FETCH: st_d = ST_D_MAC;
      ST_D_MAC: begin
        if (j_q == i_q) begin
          st_d = ST_D_STORE;
        end else begin
          j_d  = j_q + IDX_ONE;
          st_d = ST_D_FETCH;
        end
      end
      ST_D_STORE: begin
        if (i_q == nb_q) begin
          st_d = ST_DONE;
        end else begin
          i_d  = i_q + IDX_ONE;
          st_d = ST_D_INIT;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_ROW;
      nb_q   <= '0;
      i_q    <= '0;
      j_q    <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      nb_q   <= nb_d;
      i_q    <= i_d;
      j_q    <= j_d;
    end
  end

  // output decode
  always_comb begin
    busy     = (st_q != ST_IDLE);
    done     = (st_q == ST_DONE);
    a_rd     = (st_q == ST_R_FETCH) || (st_q == ST_D_FETCH);
    a_row    = (mode_q == MODE_DIAG) ? (i_q - j_q) : i_q;
    a_col    = j_q;
    b_rd     = (st_q == ST_R_FETCH);
    b_wr     = (st_q == ST_R_INIT) || (st_q == ST_R_UPD) || (st_q == ST_D_STORE);
    b_addr   = (mode_q == MODE_DIAG) ? i_q : (i_q + j_q);
    acc_init = (st_q == ST_D_INIT);
    acc_mul  = (st_q == ST_D_MAC);
    unique case (st_q)
      ST_R_INIT:  wsel = WS_ONE;
      ST_D_STORE: wsel = WS_ACC;
      default:    wsel = WS_PROD;
    endcase
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  diag_no_bread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == MODE_DIAG) |-> !b_rd);

  // R6
  a_domain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd |-> ({1'b0, a_row} + {1'b0, a_col}) <= {1'b0, nb_q});

  // R6
  b_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_rd && b_wr));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (mode_q == $past(mode_q)) && (nb_q == $past(nb_q)));

endmodule

// File: rtl/tri_nest_dpath.sv
module tri_nest_dpath
  import tri_nest_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_init,
  input  logic              acc_mul,
  input  wsel_e             wsel,
  input  logic [DATA_W-1:0] a_rd_data,
  input  logic [DATA_W-1:0] b_rd_data,
  output logic [DATA_W-1:0] b_wr_data
);

  localparam logic [DATA_W-1:0] UNIT = DATA_W'(1);

  logic [DATA_W-1:0] acc_q, acc_d;
  logic              acc_en;
  logic [DATA_W-1:0] rmw_prod;

  assign rmw_prod = b_rd_data * a_rd_data;
  assign acc_en   = acc_init | acc_mul;

  always_comb begin
    acc_d = acc_q;
    if (acc_init) begin
      acc_d = UNIT;
    end else if (acc_mul) begin
      acc_d = acc_q * a_rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_comb begin
    unique case (wsel)
      WS_ONE:  b_wr_data = UNIT;
      WS_ACC:  b_wr_data = acc_q;
      default: b_wr_data = rmw_prod;
    endcase
  end

  // R4
  acc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_init |=> (b_wr_data == UNIT) || (wsel != WS_ACC));

endmodule

// File: rtl/tri_evt_cnt.sv
module tri_evt_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | inc;

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  // R9
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt));

endmodule

// File: rtl/tri_nest_engine.sv
module tri_nest_engine
  import tri_nest_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16,
  localparam int N_MAX = (1 << IDX_W) - 1,
  localparam int T_MAX = (N_MAX + 1) * (N_MAX + 2) / 2,
  localparam int CNT_W = $clog2(T_MAX + N_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [IDX_W-1:0]  n_in,
  output logic              busy,
  output logic              done,
  output logic              a_rd_en,
  output logic [IDX_W-1:0]  a_row,
  output logic [IDX_W-1:0]  a_col,
  input  logic [DATA_W-1:0] a_rd_data,
  output logic              b_rd_en,
  output logic              b_wr_en,
  output logic [IDX_W-1:0]  b_addr,
  output logic [DATA_W-1:0] b_wr_data,
  input  logic [DATA_W-1:0] b_rd_data,
  output logic [CNT_W-1:0]  cnt_b_rd,
  output logic [CNT_W-1:0]  cnt_b_wr,
  output logic [CNT_W-1:0]  cnt_a_rd
);

  localparam int NUM_CNT = 3;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  wsel_e            wsel;
  logic             acc_init, acc_mul;
  logic             run_clr;
  logic [NUM_CNT-1:0] evt;
  logic [CNT_W-1:0] cnt_arr [NUM_CNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  tri_nest_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .mode     (mode),
    .n_in     (n_in),
    .busy     (busy),
    .done     (done),
    .a_rd     (a_rd_en),
    .a_row    (a_row),
    .a_col    (a_col),
    .b_rd     (b_rd_en),
    .b_wr     (b_wr_en),
    .b_addr   (b_addr),
    .wsel     (wsel),
    .acc_init (acc_init),
    .acc_mul  (acc_mul)
  );

  tri_nest_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_init  (acc_init),
    .acc_mul   (acc_mul),
    .wsel      (wsel),
    .a_rd_data (a_rd_data),
    .b_rd_data (b_rd_data),
    .b_wr_data (b_wr_data)
  );

  assign run_clr = start & ~busy;
  assign evt     = {a_rd_en, b_wr_en, b_rd_en};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    tri_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .clr   (run_clr),
      .inc   (evt[g]),
      .cnt   (cnt_arr[g])
    );
  end

  assign cnt_b_rd = cnt_arr[0];
  assign cnt_b_wr = cnt_arr[1];
  assign cnt_a_rd = cnt_arr[2];

endmodule

// File: tb/tri_nest_engine_test.sv
module tri_nest_engine_test;

  localparam int IDX_W = 3;
  localparam int DW    = 16;
  localparam int NM    = (1 << IDX_W) - 1;
  localparam int TM    = (NM + 1) * (NM + 2) / 2;
  localparam int CW    = $clog2(TM + NM + 2);
  localparam logic [DW-1:0] SENT = 16'hDEAD;

  logic clk = 1'b0;
  logic rst_n;
  logic start, mode;
  logic [IDX_W-1:0] n_in;
  logic busy, done, a_rd_en, b_rd_en, b_wr_en;
  logic [IDX_W-1:0] a_row, a_col, b_addr;
  logic [DW-1:0] a_rd_data, b_rd_data, b_wr_data;
  logic [CW-1:0] cnt_b_rd, cnt_b_wr, cnt_a_rd;

  logic [DW-1:0] amat [0:NM][0:NM];
  logic [DW-1:0] bmem [0:NM];
  logic [DW-1:0] bsave [0:NM];
  int errors = 0;
  int checks = 0;
  int cur_n = 0;
  int dom_viol = 0;
  logic prev_wr;

  always #2 clk = ~clk;

  tri_nest_engine #(.IDX_W(IDX_W), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .n_in(n_in),
    .busy(busy), .done(done), .a_rd_en(a_rd_en), .a_row(a_row), .a_col(a_col),
    .a_rd_data(a_rd_data), .b_rd_en(b_rd_en), .b_wr_en(b_wr_en), .b_addr(b_addr),
    .b_wr_data(b_wr_data), .b_rd_data(b_rd_data), .cnt_b_rd(cnt_b_rd),
    .cnt_b_wr(cnt_b_wr), .cnt_a_rd(cnt_a_rd)
  );

  // memory models, one-cycle read latency
  always @(posedge clk) begin
    if (a_rd_en) a_rd_data <= amat[a_row][a_col];
    if (b_rd_en) b_rd_data <= bmem[b_addr];
    if (b_wr_en) bmem[b_addr] <= b_wr_data;
    prev_wr <= b_wr_en;
    if (rst_n && a_rd_en && (int'(a_row) + int'(a_col) > cur_n)) dom_viol++;
    if (rst_n && b_rd_en && b_wr_en) dom_viol++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_b(input int k);
    logic [DW-1:0] p = 1;
    for (int r = 0; r <= k; r++) p = p * amat[r][k-r];
    return p;
  endfunction

  task automatic fill_a(input int kind);
    for (int r = 0; r <= NM; r++)
      for (int c = 0; c <= NM; c++)
        case (kind)
          0: amat[r][c] = DW'($urandom);
          1: amat[r][c] = 16'd1;
          2: amat[r][c] = 16'd2;
          default: amat[r][c] = 16'hFFFF;
        endcase
  endtask

  task automatic prefill_b();
    for (int k = 0; k <= NM; k++) bmem[k] = SENT;
  endtask

  task automatic run(input bit m, input int n);
    bit seen = 0;
    cur_n = n;
    @(negedge clk);
    mode = m; n_in = IDX_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", busy, 1);
    for (int t = 0; t < 4000 && !seen; t++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R7", "done reached", seen, 1);
    chk(prev_wr == 1'b1, "R7", "B write right before done", prev_wr, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "done one cycle then idle",
        {done, busy}, 0);
  endtask

  task automatic check_b(input int n, input string req);
    for (int k = 0; k <= NM; k++) begin
      if (k <= n) chk(bmem[k] == ref_b(k), req, $sformatf("B[%0d] n=%0d", k, n),
                      bmem[k], ref_b(k));
      else chk(bmem[k] == SENT, "R2", $sformatf("B[%0d] untouched n=%0d", k, n),
               bmem[k], SENT);
    end
  endtask

  task automatic check_cnt(input bit m, input int n);
    int t = (n + 1) * (n + 2) / 2;
    string req = m ? "R4" : "R3";
    chk(cnt_a_rd == CW'(t), req, "A reads", cnt_a_rd, t);
    chk(cnt_b_rd == CW'(m ? 0 : t), req, "B reads", cnt_b_rd, m ? 0 : t);
    chk(cnt_b_wr == CW'(m ? n + 1 : t + n + 1), req, "B writes", cnt_b_wr,
        m ? n + 1 : t + n + 1);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0, "R1", "busy/done after reset", {busy, done}, 0);
    chk(!a_rd_en && !b_rd_en && !b_wr_en, "R1", "strobes after reset",
        {a_rd_en, b_rd_en, b_wr_en}, 0);
    chk(cnt_a_rd == 0 && cnt_b_rd == 0 && cnt_b_wr == 0, "R1", "counters after reset",
        cnt_a_rd + cnt_b_rd + cnt_b_wr, 0);
  endtask

  task automatic t_pair(input int n, input int kind);
    int row_acc, diag_acc;
    logic [CW-1:0] hold;
    fill_a(kind);
    dom_viol = 0;
    prefill_b();
    run(1'b0, n);
    check_b(n, "R3");
    check_cnt(1'b0, n);
    row_acc = int'(cnt_b_rd) + int'(cnt_b_wr);
    for (int k = 0; k <= NM; k++) bsave[k] = bmem[k];
    prefill_b();
    run(1'b1, n);
    check_b(n, "R4");
    check_cnt(1'b1, n);
    diag_acc = int'(cnt_b_rd) + int'(cnt_b_wr);
    for (int k = 0; k <= n; k++)
      chk(bmem[k] == bsave[k], "R5", $sformatf("modes agree B[%0d]", k), bmem[k], bsave[k]);
    if (n >= 2) chk(diag_acc < row_acc, "R10", "diag B traffic lower", diag_acc, row_acc);
    hold = cnt_b_wr;
    repeat (5) @(negedge clk);
    chk(cnt_b_wr == hold, "R9", "counter holds when idle", cnt_b_wr, hold);
    chk(dom_viol == 0, "R6", "address domain and port exclusivity", dom_viol, 0);
  endtask

  task automatic t_busy_start();
    bit seen = 0;
    fill_a(0);
    prefill_b();
    cur_n = 5;
    @(negedge clk);
    mode = 1'b0; n_in = 3'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    mode = 1'b1; n_in = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 4000 && !seen; t++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R8", "run completes", seen, 1);
    @(negedge clk);
    check_b(5, "R8");
    check_cnt(1'b0, 5);
    chk(cnt_b_rd == CW'(21), "R8", "row mode kept", cnt_b_rd, 21);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; n_in = '0;
    prefill_b();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pair(0, 0);
    t_pair(1, 0);
    t_pair(2, 0);
    t_pair(5, 0);
    t_pair(7, 0);
    t_pair(7, 1);
    t_pair(7, 2);
    t_pair(6, 3);
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule